// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sits beside the execute stage of a 32-bit CPU core. It decides what happens when a synchronous fault is signalled, when an external interrupt level is presented, or when the core issues a return-from-handler command. Each cycle it selects at most one action and applies it at the next clock edge. On a normal entry it copies the current PC and status word into two shadow registers, sets the status block bit, records a 12-bit event code and emits a branch to a vector address. On a return it reloads PC and status from the shadows. A fault that arrives while the block bit is set cannot be handled normally. In that case the block forces a reset-like restart instead.

The status word lives inside the block. The core's own status writes, such as software clearing the block bit, arrive through a write strobe. Instruction fetch, the pipeline and the interrupt sources are outside the block. They appear only as strobes and register values at its ports.

Top module: `exc_ctl`

## Requirements
- R1: During and after synchronous reset the status word is 0x100000F0. That value has the block bit (bit 28) set, the mask field (bits 7:4) at 1111 and every other bit clear. Saved-PC, saved-status and the event code are zero, and no branch or restart is signalled.
- R2: When a fault strobe arrives and the block bit is 0, the next cycle shows a branch to VEC_BASE+0x100. In that cycle saved-PC holds the input PC, saved-status holds the prior status word, the block bit is 1 and the event code equals the fault's code.
- R3: An interrupt level L from 0000 to 1110 carries priority 15-L and event code 0x200+0x20*L, so 0010 gives 0x240 and 1110 gives 0x3C0. Level 1111 is no request.
- R4: An interrupt is taken only when the block bit is 0 and its priority is strictly greater than the mask field. Taking it branches to VEC_BASE+0x600 and saves state in the same way as R2.
- R5: While the block bit is 1, an interrupt level produces no branch and is held pending. It is taken in the cycle after the block bit returns to 0, provided it is still present and still above the mask.
- R6: A fault strobe that arrives while the block bit is 1 causes a restart. The next cycle shows restart and branch_valid high, a target of 0xA0000000, the status word at its reset value, and saved-PC, saved-status and the event code cleared.
- R7: A return command branches to saved-PC and loads the status word from saved-status, whatever the state of the block bit. The shadows and the event code are left unchanged.
- R8: Only one action is applied per cycle, in this priority order: fault, then return, then status write, then interrupt. An interrupt that loses the arbitration stays pending.
- R9: While the block bit is 1, saved-PC and saved-status do not change, except when a restart clears them.
- R10: A status write strobe loads the whole status word from the write data and produces no branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Fault strobe |
| exc_code | input | CODE_W | Code recorded for the fault |
| irq_level | input | LVL_W | Encoded interrupt level, all ones means idle |
| rte_req | input | 1 | Return-from-handler command |
| sr_wr_en | input | 1 | Status word write strobe |
| sr_wr_data | input | XLEN | Status word write data |
| pc_in | input | XLEN | PC of the current instruction |
| branch_valid | output | 1 | Branch request, one cycle |
| branch_target | output | XLEN | Branch address |
| restart | output | 1 | Reset-like restart taken |
| sr_out | output | XLEN | Status word |
| spc_out | output | XLEN | Saved PC |
| ssr_out | output | XLEN | Saved status word |
| evt_code | output | CODE_W | Event code of the last entry |

## Verification
The bound checker checks several rules in every cycle. A set block bit never lets an interrupt through. The shadows hold while blocked. A restart is caused only by a fault that arrives while blocked, and it always lands on the reset state. A return always reloads from the shadows, and every normal entry leaves the block bit set with the prior state saved. Other behaviours depend on the history of the run, and only the bench's sequences can show them. These are the level-to-code mapping at both ends of the range and the strict mask comparison at its boundary. They also include a pending interrupt surviving a lost arbitration and being taken exactly one cycle after the block bit clears.

// File: rtl/exc_ctl_pkg.sv
package exc_ctl_pkg;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_RESTART,
        ACT_EXC,
        ACT_RTE,
        ACT_SRWR,
        ACT_IRQ
    } act_e;

    localparam logic [31:0] RESTART_ADDR = 32'hA000_0000;
    localparam logic [31:0] EXC_OFFSET   = 32'h0000_0100;
    localparam logic [31:0] IRQ_OFFSET   = 32'h0000_0600;
    localparam int          IRQ_CODE_BASE = 'h200;
    localparam int          IRQ_CODE_SH   = 5;

    function automatic logic [31:0] sr_reset_word(input int bl_bit, input int mask_lsb,
                                                  input int lvl_w);
        logic [31:0] w;
        w = '0;
        w[bl_bit] = 1'b1;
        for (int i = 0; i < lvl_w; i++) begin
            w[mask_lsb + i] = 1'b1;
        end
        return w;
    endfunction

endpackage

// File: rtl/exc_irq_decode.sv
module exc_irq_decode
    import exc_ctl_pkg::*;
#(
    parameter int LVL_W  = 4,
    parameter int CODE_W = 12
) (
    input  logic [LVL_W-1:0]  level,
    input  logic [LVL_W-1:0]  imask,
    input  logic              blocked,
    output logic              eligible,
    output logic [CODE_W-1:0] code
);
    localparam logic [LVL_W-1:0] IDLE_LVL = '1;

    logic [LVL_W-1:0] prio;

    always_comb begin
        prio     = IDLE_LVL - level;
        eligible = (level != IDLE_LVL) && !blocked && (prio > imask);
        code     = CODE_W'(IRQ_CODE_BASE) + (CODE_W'(level) << IRQ_CODE_SH);
    end

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_ctl_pkg::*;
(
    input  logic exc_req,
    input  logic rte_req,
    input  logic sr_wr_en,
    input  logic irq_ok,
    input  logic blocked,
    output act_e act
);
    always_comb begin
        if (exc_req)       act = blocked ? ACT_RESTART : ACT_EXC;
        else if (rte_req)  act = ACT_RTE;
        else if (sr_wr_en) act = ACT_SRWR;
        else if (irq_ok)   act = ACT_IRQ;
        else               act = ACT_IDLE;
    end
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
    import exc_ctl_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              CODE_W   = 12,
    parameter int              LVL_W    = 4,
    parameter int              BL_BIT   = 28,
    parameter int              MASK_LSB = 4,
    parameter logic [XLEN-1:0] VEC_BASE = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  act_e              act,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   sr_wr_data,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [CODE_W-1:0] irq_code,
    output logic [XLEN-1:0]   sr_q,
    output logic [XLEN-1:0]   spc_q,
    output logic [XLEN-1:0]   ssr_q,
    output logic [CODE_W-1:0] evt_q,
    output logic              bv_q,
    output logic              rs_q,
    output logic [XLEN-1:0]   tgt_q
);
    localparam logic [XLEN-1:0] SR_RST   = XLEN'(sr_reset_word(BL_BIT, MASK_LSB, LVL_W));
    localparam logic [XLEN-1:0] BL_MASK  = XLEN'(1) << BL_BIT;
    localparam logic [XLEN-1:0] EXC_VEC  = VEC_BASE + XLEN'(EXC_OFFSET);
    localparam logic [XLEN-1:0] IRQ_VEC  = VEC_BASE + XLEN'(IRQ_OFFSET);
    localparam logic [XLEN-1:0] RST_VEC  = XLEN'(RESTART_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= SR_RST;
            spc_q <= '0;
            ssr_q <= '0;
            evt_q <= '0;
            bv_q  <= 1'b0;
            rs_q  <= 1'b0;
            tgt_q <= '0;
        end else begin
            bv_q <= 1'b0;
            rs_q <= 1'b0;
            unique case (act)
                ACT_RESTART: begin
                    sr_q  <= SR_RST;
                    spc_q <= '0;
                    ssr_q <= '0;
                    evt_q <= '0;
                    bv_q  <= 1'b1;
                    rs_q  <= 1'b1;
                    tgt_q <= RST_VEC;
                end
                ACT_EXC: begin
                    spc_q <= pc_in;
                    ssr_q <= sr_q;
                    sr_q  <= sr_q | BL_MASK;
                    evt_q <= exc_code;
                    bv_q  <= 1'b1;
                    tgt_q <= EXC_VEC;
                end
                ACT_IRQ: begin
                    spc_q <= pc_in;
                    ssr_q <= sr_q;
                    sr_q  <= sr_q | BL_MASK;
                    evt_q <= irq_code;
                    bv_q  <= 1'b1;
                    tgt_q <= IRQ_VEC;
                end
                ACT_RTE: begin
                    sr_q  <= ssr_q;
                    bv_q  <= 1'b1;
                    tgt_q <= spc_q;
                end
                ACT_SRWR: begin
                    sr_q <= sr_wr_data;
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/exc_ctl.sv
module exc_ctl
    import exc_ctl_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              CODE_W   = 12,
    parameter int              LVL_W    = 4,
    parameter int              BL_BIT   = 28,
    parameter int              MASK_LSB = 4,
    parameter logic [XLEN-1:0] VEC_BASE = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic              rte_req,
    input  logic              sr_wr_en,
    input  logic [XLEN-1:0]   sr_wr_data,
    input  logic [XLEN-1:0]   pc_in,
    output logic              branch_valid,
    output logic [XLEN-1:0]   branch_target,
    output logic              restart,
    output logic [XLEN-1:0]   sr_out,
    output logic [XLEN-1:0]   spc_out,
    output logic [XLEN-1:0]   ssr_out,
    output logic [CODE_W-1:0] evt_code
);
    logic              blocked;
    logic              irq_ok;
    logic [CODE_W-1:0] irq_code;
    act_e              act;

    assign blocked = sr_out[BL_BIT];

    exc_irq_decode #(.LVL_W(LVL_W), .CODE_W(CODE_W)) u_dec (
        .level    (irq_level),
        .imask    (sr_out[MASK_LSB +: LVL_W]),
        .blocked  (blocked),
        .eligible (irq_ok),
        .code     (irq_code)
    );

    exc_arbiter u_arb (
        .exc_req  (exc_req),
        .rte_req  (rte_req),
        .sr_wr_en (sr_wr_en),
        .irq_ok   (irq_ok),
        .blocked  (blocked),
        .act      (act)
    );

    exc_state_regs #(
        .XLEN(XLEN), .CODE_W(CODE_W), .LVL_W(LVL_W),
        .BL_BIT(BL_BIT), .MASK_LSB(MASK_LSB), .VEC_BASE(VEC_BASE)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .act        (act),
        .pc_in      (pc_in),
        .sr_wr_data (sr_wr_data),
        .exc_code   (exc_code),
        .irq_code   (irq_code),
        .sr_q       (sr_out),
        .spc_q      (spc_out),
        .ssr_q      (ssr_out),
        .evt_q      (evt_code),
        .bv_q       (branch_valid),
        .rs_q       (restart),
        .tgt_q      (branch_target)
    );
endmodule

// File: rtl/exc_ctl_checker.sv
module exc_ctl_checker
    import exc_ctl_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int CODE_W   = 12,
    parameter int LVL_W    = 4,
    parameter int BL_BIT   = 28,
    parameter int MASK_LSB = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              exc_req,
    input logic [CODE_W-1:0] exc_code,
    input logic [LVL_W-1:0]  irq_level,
    input logic              rte_req,
    input logic              sr_wr_en,
    input logic [XLEN-1:0]   sr_wr_data,
    input logic [XLEN-1:0]   pc_in,
    input logic              branch_valid,
    input logic [XLEN-1:0]   branch_target,
    input logic              restart,
    input logic [XLEN-1:0]   sr_out,
    input logic [XLEN-1:0]   spc_out,
    input logic [XLEN-1:0]   ssr_out,
    input logic [CODE_W-1:0] evt_code
);
    localparam logic [XLEN-1:0] SR_RST = XLEN'(sr_reset_word(BL_BIT, MASK_LSB, LVL_W));

    // R1: leaving reset shows the reset status word and no branch
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sr_out == SR_RST) && !branch_valid && !restart);

    // R6: restart lands on the reset state and address
    p_restart_state_r6: assert property (@(posedge clk) disable iff (rst)
        restart |-> branch_valid && (branch_target == XLEN'(RESTART_ADDR))
                    && (sr_out == SR_RST) && (spc_out == '0) && (ssr_out == '0));

    // R6: restart only follows a fault raised while blocked
    p_restart_cause_r6: assert property (@(posedge clk) disable iff (rst)
        restart |-> $past(exc_req) && $past(sr_out[BL_BIT]));

    // R5: no interrupt gets through while blocked
    p_irq_blocked_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(sr_out[BL_BIT]) && !$past(exc_req) && !$past(rte_req)) |-> !branch_valid);

    // R9: shadows hold while blocked, restart aside
    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(sr_out[BL_BIT]) && !restart) |-> $stable(spc_out) && $stable(ssr_out));

    // R7: a return reloads from the shadows
    p_rte_restore_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(rte_req) && !$past(exc_req)) |->
            branch_valid && (branch_target == $past(spc_out)) && (sr_out == $past(ssr_out)));

    // R2: a normal entry sets the block bit and saves prior state
    p_entry_save_r2: assert property (@(posedge clk) disable iff (rst)
        (branch_valid && !restart && !$past(rte_req)) |->
            sr_out[BL_BIT] && (ssr_out == $past(sr_out)) && (spc_out == $past(pc_in)));

    // R8: an unblocked fault always wins the cycle
    p_exc_first_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(exc_req) && !$past(sr_out[BL_BIT])) |->
            branch_valid && !restart && (evt_code == $past(exc_code)));
endmodule

bind exc_ctl exc_ctl_checker #(
    .XLEN(XLEN), .CODE_W(CODE_W), .LVL_W(LVL_W), .BL_BIT(BL_BIT), .MASK_LSB(MASK_LSB)
) u_chk (.*);

// File: tb/exc_ctl_bench.sv
module exc_ctl_bench;

    typedef struct packed {
        logic        exc;
        logic [11:0] code;
        logic [3:0]  lvl;
        logic        rte;
        logic        wr;
        logic [31:0] wdata;
        logic [31:0] pc;
        logic        e_valid;
        logic        e_rst;
        logic [31:0] e_tgt;
        logic [31:0] e_sr;
        logic [31:0] e_spc;
        logic [31:0] e_ssr;
        logic [11:0] e_evt;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        // R10: clear block bit, mask 3
        '{1'b0, 12'h0, 4'hF, 1'b0, 1'b1, 32'h30, 32'h0, 1'b0, 1'b0, 32'h0, 32'h30, 32'h0, 32'h0, 12'h0, 4'd10},
        // R4: level 2 (prio 13) above mask 3
        '{1'b0, 12'h0, 4'h2, 1'b0, 1'b0, 32'h0, 32'h1000, 1'b1, 1'b0, 32'h8000_0600, 32'h1000_0030, 32'h1000, 32'h30, 12'h240, 4'd4},
        // R9: still asserted, blocked, shadows hold
        '{1'b0, 12'h0, 4'h2, 1'b0, 1'b0, 32'h0, 32'h1100, 1'b0, 1'b0, 32'h0, 32'h1000_0030, 32'h1000, 32'h30, 12'h240, 4'd9},
        // R7: return
        '{1'b0, 12'h0, 4'hF, 1'b1, 1'b0, 32'h0, 32'h1200, 1'b1, 1'b0, 32'h1000, 32'h30, 32'h1000, 32'h30, 12'h240, 4'd7},
        // R4: level C (prio 3) not above mask 3
        '{1'b0, 12'h0, 4'hC, 1'b0, 1'b0, 32'h0, 32'h1300, 1'b0, 1'b0, 32'h0, 32'h30, 32'h1000, 32'h30, 12'h240, 4'd4},
        // R3: level B (prio 4) gives code 0x360
        '{1'b0, 12'h0, 4'hB, 1'b0, 1'b0, 32'h0, 32'h2000, 1'b1, 1'b0, 32'h8000_0600, 32'h1000_0030, 32'h2000, 32'h30, 12'h360, 4'd3},
        // R7: return
        '{1'b0, 12'h0, 4'hF, 1'b1, 1'b0, 32'h0, 32'h2100, 1'b1, 1'b0, 32'h2000, 32'h30, 32'h2000, 32'h30, 12'h360, 4'd7},
        // R8: fault and interrupt together, fault wins
        '{1'b1, 12'h1E0, 4'h5, 1'b0, 1'b0, 32'h0, 32'h3000, 1'b1, 1'b0, 32'h8000_0100, 32'h1000_0030, 32'h3000, 32'h30, 12'h1E0, 4'd8},
        // R5: interrupt held while blocked
        '{1'b0, 12'h0, 4'h5, 1'b0, 1'b0, 32'h0, 32'h3100, 1'b0, 1'b0, 32'h0, 32'h1000_0030, 32'h3000, 32'h30, 12'h1E0, 4'd5},
        // R8: status write beats the interrupt
        '{1'b0, 12'h0, 4'h5, 1'b0, 1'b1, 32'h30, 32'h3200, 1'b0, 1'b0, 32'h0, 32'h30, 32'h3000, 32'h30, 12'h1E0, 4'd8},
        // R5: pending interrupt taken the cycle after unblock
        '{1'b0, 12'h0, 4'h5, 1'b0, 1'b0, 32'h0, 32'h4000, 1'b1, 1'b0, 32'h8000_0600, 32'h1000_0030, 32'h4000, 32'h30, 12'h2A0, 4'd5},
        // R6: fault while blocked -> restart
        '{1'b1, 12'h0E0, 4'hF, 1'b0, 1'b0, 32'h0, 32'h5000, 1'b1, 1'b1, 32'hA000_0000, 32'h1000_00F0, 32'h0, 32'h0, 12'h0, 4'd6},
        // R5: top priority level still blocked
        '{1'b0, 12'h0, 4'h0, 1'b0, 1'b0, 32'h0, 32'h5100, 1'b0, 1'b0, 32'h0, 32'h1000_00F0, 32'h0, 32'h0, 12'h0, 4'd5},
        // R10: clear everything, mask 0
        '{1'b0, 12'h0, 4'hF, 1'b0, 1'b1, 32'h0, 32'h5200, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0, 12'h0, 4'd10},
        // R3: level E (prio 1) gives code 0x3C0
        '{1'b0, 12'h0, 4'hE, 1'b0, 1'b0, 32'h0, 32'h6000, 1'b1, 1'b0, 32'h8000_0600, 32'h1000_0000, 32'h6000, 32'h0, 12'h3C0, 4'd3},
        // R7: return
        '{1'b0, 12'h0, 4'hF, 1'b1, 1'b0, 32'h0, 32'h6100, 1'b1, 1'b0, 32'h6000, 32'h0, 32'h6000, 32'h0, 12'h3C0, 4'd7},
        // R3: level 1111 means idle
        '{1'b0, 12'h0, 4'hF, 1'b0, 1'b0, 32'h0, 32'h6200, 1'b0, 1'b0, 32'h0, 32'h0, 32'h6000, 32'h0, 12'h3C0, 4'd3}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        exc_req;
    logic [11:0] exc_code;
    logic [3:0]  irq_level;
    logic        rte_req;
    logic        sr_wr_en;
    logic [31:0] sr_wr_data;
    logic [31:0] pc_in;
    logic        branch_valid;
    logic [31:0] branch_target;
    logic        restart;
    logic [31:0] sr_out;
    logic [31:0] spc_out;
    logic [31:0] ssr_out;
    logic [11:0] evt_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    exc_ctl u_exc_ctl (
        .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code),
        .irq_level(irq_level), .rte_req(rte_req), .sr_wr_en(sr_wr_en),
        .sr_wr_data(sr_wr_data), .pc_in(pc_in), .branch_valid(branch_valid),
        .branch_target(branch_target), .restart(restart), .sr_out(sr_out),
        .spc_out(spc_out), .ssr_out(ssr_out), .evt_code(evt_code)
    );

    task automatic check(input string what, input int rq, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        exc_req = 1'b0; exc_code = '0; irq_level = 4'hF; rte_req = 1'b0;
        sr_wr_en = 1'b0; sr_wr_data = '0; pc_in = '0;
    endtask

    task automatic check_reset_state(input string tag);
        check({tag, " sr"},    1, sr_out, 32'h1000_00F0);
        check({tag, " spc"},   1, spc_out, 32'h0);
        check({tag, " ssr"},   1, ssr_out, 32'h0);
        check({tag, " evt"},   1, 32'(evt_code), 32'h0);
        check({tag, " valid"}, 1, 32'(branch_valid), 32'h0);
        check({tag, " rst"},   1, 32'(restart), 32'h0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: state held in reset
        check_reset_state("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_reset_state("R1 after reset");

        for (int i = 0; i < NV; i++) begin
            exc_req    = VECS[i].exc;
            exc_code   = VECS[i].code;
            irq_level  = VECS[i].lvl;
            rte_req    = VECS[i].rte;
            sr_wr_en   = VECS[i].wr;
            sr_wr_data = VECS[i].wdata;
            pc_in      = VECS[i].pc;
            @(negedge clk);
            check($sformatf("vec%0d valid", i), int'(VECS[i].req), 32'(branch_valid), 32'(VECS[i].e_valid));
            check($sformatf("vec%0d restart", i), int'(VECS[i].req), 32'(restart), 32'(VECS[i].e_rst));
            if (VECS[i].e_valid)
                check($sformatf("vec%0d target", i), int'(VECS[i].req), branch_target, VECS[i].e_tgt);
            check($sformatf("vec%0d sr", i), int'(VECS[i].req), sr_out, VECS[i].e_sr);
            check($sformatf("vec%0d spc", i), int'(VECS[i].req), spc_out, VECS[i].e_spc);
            check($sformatf("vec%0d ssr", i), int'(VECS[i].req), ssr_out, VECS[i].e_ssr);
            check($sformatf("vec%0d evt", i), int'(VECS[i].req), 32'(evt_code), 32'(VECS[i].e_evt));
        end

        // R1: reset in the middle of a run
        idle_inputs();
        sr_wr_en = 1'b1; sr_wr_data = 32'h55;
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_reset_state("R1 mid-run");

        // R8: fault plus return while blocked, fault wins and restarts (R6)
        exc_req = 1'b1; exc_code = 12'h0C0; rte_req = 1'b1; pc_in = 32'h7000;
        @(negedge clk);
        idle_inputs();
        check("R8 restart wins", 8, 32'(restart), 32'h1);
        check("R6 restart target", 6, branch_target, 32'hA000_0000);

        // R2: unblock, then plain fault
        sr_wr_en = 1'b1; sr_wr_data = 32'h0000_00A0;
        @(negedge clk);
        idle_inputs();
        exc_req = 1'b1; exc_code = 12'h1A0; pc_in = 32'h7100;
        @(negedge clk);
        idle_inputs();
        check("R2 target", 2, branch_target, 32'h8000_0100);
        check("R2 sr", 2, sr_out, 32'h1000_00A0);
        check("R2 ssr", 2, ssr_out, 32'h0000_00A0);
        check("R2 spc", 2, spc_out, 32'h7100);
        check("R2 evt", 2, 32'(evt_code), 32'h1A0);

        // R7: return while unblocked still branches to saved PC
        sr_wr_en = 1'b1; sr_wr_data = 32'h0;
        @(negedge clk);
        idle_inputs();
        rte_req = 1'b1;
        @(negedge clk);
        idle_inputs();
        check("R7 unblocked return target", 7, branch_target, 32'h7100);
        check("R7 unblocked return sr", 7, sr_out, 32'h0000_00A0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule